// File: doc/BRIEF.md
# Way-Tag Queue with L2 Way-Enable Decoder

This block keeps, for every write operation waiting to go from the L1 data cache to the L2 cache, the L2 way that the operation should touch and whether that way is known. It is a first-in first-out queue driven by the same push and pop strobes as the L1-to-L2 write buffer. Because the strobes are shared, the queue always holds the same number of entries as the write buffer, and its head always belongs to the operation at the head of the write buffer.

Each entry holds an L2 way number and a known-way flag. The flag is set when the originating access was an L1 write hit, because the way number was recorded when the line was filled. It is clear for an L1 write miss or a read miss. A decoder on the head entry produces one enable per L2 way. When the flag is set, only the recorded way is enabled. When the flag is clear, every way is enabled. When the queue is empty, no request is being issued and all enables are low.

A push on a full queue without a pop, and a pop on an empty queue, are dropped. In both cases the error output is raised in the same cycle.

Top module: `waytag_queue`

## Requirements
- R1: While reset is held and just after it is released, `empty` is 1, `full` is 0, `err` is 0 and `way_en` is all zeros.
- R2: Entries leave the queue in the order they were pushed. A pop is the cycle in which `pop` is 1 and `empty` is 0, sampled at the rising clock edge.
- R3: When the head entry has `in_hit`=1 recorded, `way_en` has exactly one bit set. That bit is bit number `in_way` of the entry (bit 0 = way 0).
- R4: When the head entry has `in_hit`=0 recorded, every bit of `way_en` is 1.
- R5: When the queue is empty, every bit of `way_en` is 0.
- R6: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held.
- R7: A push while full and without a pop is ignored: the stored entries and their order are unchanged, and `err` is 1 in that cycle.
- R8: A pop while empty is ignored: the queue stays empty, and `err` is 1 in that cycle.
- R9: A push together with a pop while full performs both operations, and `err` stays 0.
- R10: A push together with a pop while empty stores the new entry, discards the pop, and raises `err` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Push strobe shared with the write buffer |
| pop | input | 1 | Pop strobe shared with the write buffer |
| in_way | input | WAY_W | L2 way number of the pushed operation |
| in_hit | input | 1 | 1 if the pushed operation was an L1 write hit |
| way_en | output | WAYS | Per-way L2 enables for the head entry |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds DEPTH entries |
| err | output | 1 | Push on full without pop, or pop on empty, in this cycle |

## Verification
The in-module assertions check several properties on every cycle: the decoder output has the right shape for a known-way head, all enables are low when empty, the occupancy never exceeds the depth, and a dropped push or pop leaves the occupancy unchanged. Only the bench scenarios can show that entries drain in push order with their exact way numbers and flags. The same holds for R7: that a rejected push on a full queue leaves the stored contents intact can only be seen by draining afterwards. The bench's queue model compares the enables of every head entry during long random push and pop traffic.

// File: rtl/waytag_queue.sv
module waytag_queue #(
  parameter int DEPTH = 8,
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WAY_W-1:0] in_way,
  input  logic             in_hit,
  output logic [WAYS-1:0]  way_en,
  output logic             empty,
  output logic             full,
  output logic             err
);

  logic [WAY_W-1:0] way_q [DEPTH];
  logic [DEPTH-1:0] hit_q;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign err     = (push & ~do_push) | (pop & ~do_pop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
    end else if (do_push) begin
      hit_q[wr_ptr] <= in_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) way_q[wr_ptr] <= in_way;
  end

  logic [WAY_W-1:0] head_way;
  logic             head_hit;
  assign head_way = way_q[rd_ptr];
  assign head_hit = hit_q[rd_ptr];

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_dec
      assign way_en[g] = ~empty & (~head_hit | (head_way == WAY_W'(g)));
    end
  endgenerate

  assert_known_way_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && head_hit) |-> ($countones(way_en) == 1));
  assert_unknown_way_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !head_hit) |-> (way_en == {WAYS{1'b1}}));
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (way_en == '0));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_full_push_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wr_ptr) && $stable(rd_ptr)));
  assert_empty_pop_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  assert_full_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |-> !err ##1 full);

endmodule

// File: tb/tb_waytag_queue.sv
`timescale 1ns/1ps
module tb_waytag_queue;
  localparam int DEPTH = 8;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, push = 1'b0, pop = 1'b0, in_hit = 1'b0;
  logic [WAY_W-1:0] in_way = '0;
  logic [WAYS-1:0] way_en;
  logic empty, full, err;

  int tests = 0, fails = 0;
  logic [WAY_W:0] mq [$];

  waytag_queue #(.DEPTH(DEPTH), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .in_way(in_way),
    .in_hit(in_hit), .way_en(way_en), .empty(empty), .full(full), .err(err));

  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [WAYS-1:0] exp_en();
    if (mq.size() == 0) return '0;
    if (mq[0][WAY_W]) return WAYS'(1) << mq[0][WAY_W-1:0];
    return {WAYS{1'b1}};
  endfunction

  task automatic check_state();
    string rq;
    rq = (mq.size() == 0) ? "R5" : (mq[0][WAY_W] ? "R3 R2" : "R4 R2");
    chk(32'(way_en), 32'(exp_en()), rq);
    chk(32'(empty), 32'(mq.size() == 0), "R6 empty");
    chk(32'(full), 32'(mq.size() == DEPTH), "R6 full");
  endtask

  task automatic step(input bit ps, input bit pp, input logic [WAY_W-1:0] tg,
                      input bit ht, input string rq);
    bit popok, pushok;
    check_state();
    push = ps; pop = pp; in_way = tg; in_hit = ht;
    #1;
    popok  = pp && mq.size() > 0;
    pushok = ps && (mq.size() < DEPTH || popok);
    chk(32'(err), 32'((ps && !pushok) || (pp && !popok)), rq);
    @(posedge clk);
    if (popok) void'(mq.pop_front());
    if (pushok) mq.push_back({ht, tg});
    @(negedge clk);
    push = 0; pop = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(32'(empty), 1, "R1 empty");
    chk(32'(full), 0, "R1 full");
    chk(32'(way_en), 0, "R1 way_en");
    chk(32'(err), 0, "R1 err");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(way_en), 0, "R1 way_en after release");
    step(0, 1, 0, 0, "R8");
    step(1, 1, 2'd3, 1, "R10");
    step(0, 1, 0, 0, "R2");
    for (int i = 0; i < DEPTH; i++) step(1, 0, WAY_W'(i), 1, "R6");
    step(1, 0, 2'd1, 0, "R7");
    step(1, 0, 2'd2, 0, "R7");
    step(1, 1, 2'd2, 0, "R9");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, "R2");
    step(0, 1, 0, 0, "R8");
    step(1, 0, 2'd0, 0, "R4");
    step(1, 0, 2'd1, 1, "R3");
    step(0, 1, 0, 0, "R4");
    step(0, 1, 0, 0, "R3");
    for (int i = 0; i < 3000; i++)
      step(($urandom % 100) < 55, ($urandom % 100) < 50,
           WAY_W'($urandom), $urandom % 2, "R2");
    check_state();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule